// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block walks the control strobes of an on-chip flash array through one single-block erase. A one-cycle `start` pulse carries a byte address. The address is mapped to one bit of one of two block-select groups. The sequencer then raises the write-enable strobe, loads the block-select register, arms an abort timer, raises the erase-setup strobe and finally the erase strobe. The erase strobe stays high for a fixed pulse length, which is kept below a hard ceiling. The strobes are then released in reverse order. After a recovery delay, `done` is raised.

All delays are parameters counted in clock cycles. Their defaults are derived from a clock-frequency parameter: 1 µs of write-enable lead, 100 µs of erase setup, a 5 ms erase pulse under a 10 ms ceiling, and 100 µs of recovery. The erase begins directly from the selected block; there is no zero-fill pass beforehand. The abort timer is armed when the block is selected. If the sequence has not let go of the write-enable strobe before the timer runs out, every strobe drops in the same cycle and a sticky timeout flag is raised. The sequence carries only control, so every pin is a plain level or pulse and there is no handshake. A request that arrives while the block is busy is dropped, not queued.

Top module: `flash_erase_seq`

## Requirements
- R1: During and after reset, `swe`, `esu`, `ers`, `blk_lo`, `blk_hi`, `busy`, `done`, `timeout` and `addr_err` are all 0.
- R2: An accepted start raises `swe` on the next clock edge while every other strobe and both block groups are still 0. The block-select register loads exactly `SWE_CYC` cycles after `swe` rises.
- R3: An address below 0x08000 sets bit addr[14:12] of `blk_lo` (eight 4 KiB blocks). An address from 0x08000 to 0x3FFFF sets bit (addr[17:15] − 1) of `blk_hi` (seven 32 KiB blocks). The other group stays 0, and at most one bit across both groups is ever set.
- R4: `esu` rises one cycle after the block register loads; the abort timer is armed on that load. `ers` rises exactly `ESU_CYC` cycles after `esu`.
- R5: `ers` stays high for exactly `ERASE_CYC` cycles and never for `ERASE_MAX_CYC` cycles or more.
- R6: Release order: `esu` falls `HOLD_CYC` cycles after `ers` falls, the block groups clear one cycle later, and `swe` falls one cycle after that.
- R7: `done` rises and `busy` falls exactly `POST_CYC` cycles after `swe` falls. `done` stays high until the next accepted start clears it.
- R8: A start pulse while `busy` is 1 has no effect, whatever its address. The block selection, every strobe edge time and `addr_err` stay as for the first request.
- R9: A start while idle with an address of 0x40000 or above sets `addr_err` on the next edge. No strobe, block group, `busy` or `done` changes. `addr_err` clears on the next accepted start.
- R10: If `WDOG_CYC` cycles pass after the block register loads and `swe` has not yet been released, then on that edge all strobes and block groups drop to 0, `busy` falls, `done` stays 0 and `timeout` rises. `timeout` holds until the next accepted start clears it.
- R11: `ers` is high only while `esu`, `swe` and a block bit are also high, and `esu` is high only while `swe` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle erase request |
| addr | input | ADDR_W | Byte address inside the block to erase |
| swe | output | 1 | Software write-enable strobe |
| esu | output | 1 | Erase-setup strobe |
| ers | output | 1 | Erase strobe; its high time is the erase time |
| blk_lo | output | LO_BLKS | Block-select register, low address group |
| blk_hi | output | HI_BLKS | Block-select register, high address group |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed normally |
| timeout | output | 1 | Last sequence was aborted by the timer (sticky) |
| addr_err | output | 1 | Last request was rejected as out of range |

## Verification
The sequence is driven with directed addresses at both edges of each group: 0x00000, 0x07FFF, 0x08000 and 0x3FFFF. These show whether the group boundary and the bit-index offset in the high group are placed correctly. Seeded random addresses, about one in nine of them out of range, then check the decode and the rejection path together. A second request injected mid-sequence, with a valid or an invalid address, shows whether the busy lock holds, because any disturbance moves a strobe edge or changes the captured block. A second instance with a short abort limit cuts into the erase pulse. It separates a correct simultaneous abort from a late or partial one, and shows whether the timeout flag is sticky until the next start.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SWE_WAIT,
    ST_ARM,
    ST_ESU_WAIT,
    ST_ERASE,
    ST_HOLD,
    ST_DROP_BLK,
    ST_DROP_SWE,
    ST_POST
  } seq_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fe_block_decode.sv
module fe_block_decode #(
  parameter int ADDR_W    = 20,
  parameter int LO_LIMIT  = 'h8000,
  parameter int TOP_LIMIT = 'h40000,
  parameter int LO_SHIFT  = 12,
  parameter int HI_SHIFT  = 15,
  parameter int LO_BLKS   = 8,
  parameter int HI_BLKS   = 7
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               in_range,
  output logic [LO_BLKS-1:0] lo_sel,
  output logic [HI_BLKS-1:0] hi_sel
);

  localparam int HI_BASE = LO_LIMIT >> HI_SHIFT;

  logic in_lo;
  logic in_hi;
  logic [ADDR_W-1:0] lo_idx;
  logic [ADDR_W-1:0] hi_idx;

  assign in_lo    = addr < ADDR_W'(LO_LIMIT);
  assign in_range = addr < ADDR_W'(TOP_LIMIT);
  assign in_hi    = in_range && !in_lo;
  assign lo_idx   = addr >> LO_SHIFT;
  assign hi_idx   = addr >> HI_SHIFT;

  // one comparator per block bit in each group
  for (genvar i = 0; i < LO_BLKS; i++) begin : g_lo
    assign lo_sel[i] = in_lo && (lo_idx == ADDR_W'(i));
  end

  for (genvar j = 0; j < HI_BLKS; j++) begin : g_hi
    assign hi_sel[j] = in_hi && (hi_idx == ADDR_W'(HI_BASE + j));
  end

endmodule

// File: rtl/fe_delay_timer.sv
module fe_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  // a load of N-1 gives a phase of N cycles before expired is acted on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/fe_watchdog.sv
module fe_watchdog #(
  parameter int LIMIT = 1000,
  localparam int WD_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  output logic expire
);

  logic            armed_q;
  logic [WD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (disarm) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // fires on the LIMIT-th edge after the arming edge
  assign expire = armed_q && (cnt_q == WD_W'(LIMIT - 1));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int CLK_MHZ       = 125,
  parameter int SWE_CYC       = CLK_MHZ * 1,
  parameter int ESU_CYC       = CLK_MHZ * 100,
  parameter int ERASE_CYC     = CLK_MHZ * 5000,
  parameter int ERASE_MAX_CYC = CLK_MHZ * 10000,
  parameter int HOLD_CYC      = CLK_MHZ * 10,
  parameter int POST_CYC      = CLK_MHZ * 100,
  parameter int WDOG_CYC      = CLK_MHZ * 8000,
  parameter int ADDR_W        = 20,
  parameter int LO_LIMIT      = 'h8000,
  parameter int TOP_LIMIT     = 'h40000,
  parameter int LO_SHIFT      = 12,
  parameter int HI_SHIFT      = 15,
  localparam int LO_BLKS      = LO_LIMIT >> LO_SHIFT,
  localparam int HI_BLKS      = (TOP_LIMIT - LO_LIMIT) >> HI_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  addr,
  output logic               swe,
  output logic               esu,
  output logic               ers,
  output logic [LO_BLKS-1:0] blk_lo,
  output logic [HI_BLKS-1:0] blk_hi,
  output logic               busy,
  output logic               done,
  output logic               timeout,
  output logic               addr_err
);

  localparam int MAX_CYC = max_int(max_int(max_int(SWE_CYC, ESU_CYC),
                                           max_int(ERASE_CYC, HOLD_CYC)), POST_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e state_q;

  logic               dec_ok;
  logic [LO_BLKS-1:0] dec_lo;
  logic [HI_BLKS-1:0] dec_hi;
  logic [LO_BLKS-1:0] lo_pend_q;
  logic [HI_BLKS-1:0] hi_pend_q;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_exp;

  logic wd_arm;
  logic wd_disarm;
  logic wd_expire;
  logic accept;

  fe_block_decode #(
    .ADDR_W   (ADDR_W),
    .LO_LIMIT (LO_LIMIT),
    .TOP_LIMIT(TOP_LIMIT),
    .LO_SHIFT (LO_SHIFT),
    .HI_SHIFT (HI_SHIFT),
    .LO_BLKS  (LO_BLKS),
    .HI_BLKS  (HI_BLKS)
  ) u_decode (
    .addr    (addr),
    .in_range(dec_ok),
    .lo_sel  (dec_lo),
    .hi_sel  (dec_hi)
  );

  fe_delay_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_exp)
  );

  fe_watchdog #(
    .LIMIT(WDOG_CYC)
  ) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (wd_arm),
    .disarm(wd_disarm),
    .expire(wd_expire)
  );

  assign accept    = (state_q == ST_IDLE) && start && dec_ok;
  assign wd_arm    = (state_q == ST_SWE_WAIT) && tmr_exp;
  assign wd_disarm = (state_q == ST_DROP_SWE) || wd_expire;
  assign busy      = (state_q != ST_IDLE);

  // timer reload on every transition into a timed phase
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        tmr_load = accept;
        tmr_val  = CNT_W'(SWE_CYC - 1);
      end
      ST_ARM: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(ESU_CYC - 1);
      end
      ST_ESU_WAIT: begin
        tmr_load = tmr_exp;
        tmr_val  = CNT_W'(ERASE_CYC - 1);
      end
      ST_ERASE: begin
        tmr_load = tmr_exp;
        tmr_val  = CNT_W'(HOLD_CYC - 1);
      end
      ST_DROP_SWE: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(POST_CYC - 1);
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      swe       <= 1'b0;
      esu       <= 1'b0;
      ers       <= 1'b0;
      blk_lo    <= '0;
      blk_hi    <= '0;
      lo_pend_q <= '0;
      hi_pend_q <= '0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      addr_err  <= 1'b0;
    end else if (wd_expire) begin
      // abort: every strobe low in one edge
      state_q <= ST_IDLE;
      swe     <= 1'b0;
      esu     <= 1'b0;
      ers     <= 1'b0;
      blk_lo  <= '0;
      blk_hi  <= '0;
      timeout <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            swe       <= 1'b1;
            done      <= 1'b0;
            timeout   <= 1'b0;
            addr_err  <= 1'b0;
            lo_pend_q <= dec_lo;
            hi_pend_q <= dec_hi;
            state_q   <= ST_SWE_WAIT;
          end else if (start) begin
            addr_err <= 1'b1;
          end
        end
        ST_SWE_WAIT: begin
          if (tmr_exp) begin
            blk_lo  <= lo_pend_q;
            blk_hi  <= hi_pend_q;
            state_q <= ST_ARM;
          end
        end
        ST_ARM: begin
          esu     <= 1'b1;
          state_q <= ST_ESU_WAIT;
        end
        ST_ESU_WAIT: begin
          if (tmr_exp) begin
            ers     <= 1'b1;
            state_q <= ST_ERASE;
          end
        end
        ST_ERASE: begin
          if (tmr_exp) begin
            ers     <= 1'b0;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (tmr_exp) begin
            esu     <= 1'b0;
            state_q <= ST_DROP_BLK;
          end
        end
        ST_DROP_BLK: begin
          blk_lo  <= '0;
          blk_hi  <= '0;
          state_q <= ST_DROP_SWE;
        end
        ST_DROP_SWE: begin
          swe     <= 1'b0;
          state_q <= ST_POST;
        end
        ST_POST: begin
          if (tmr_exp) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fe_seq_chk.sv
module fe_seq_chk #(
  parameter int ERASE_MAX_CYC = 16,
  parameter int ADDR_W        = 20,
  parameter int TOP_LIMIT     = 'h40000,
  parameter int LO_BLKS       = 8,
  parameter int HI_BLKS       = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [ADDR_W-1:0]  addr,
  input logic               swe,
  input logic               esu,
  input logic               ers,
  input logic [LO_BLKS-1:0] blk_lo,
  input logic [HI_BLKS-1:0] blk_hi,
  input logic               busy,
  input logic               done,
  input logic               timeout,
  input logic               addr_err
);

  logic [31:0] ers_run_q;
  logic        blk_any;

  assign blk_any = (|blk_lo) || (|blk_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ers_run_q <= '0;
    else if (ers) ers_run_q <= ers_run_q + 1;
    else          ers_run_q <= '0;
  end

  // R11
  erase_needs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ers |-> (esu && swe && blk_any));

  // R11
  setup_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esu |-> swe);

  // R5
  erase_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ers |-> (ers_run_q < 32'(ERASE_MAX_CYC)));

  // R2
  enable_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swe) |-> (!esu && !ers && !blk_any));

  // R6
  enable_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swe) |-> (!esu && !ers && !blk_any));

  // R3
  block_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({blk_hi, blk_lo}));

  // R9
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (32'(addr) >= TOP_LIMIT)) |=> (addr_err && !swe && !busy));

  // R10
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (!swe && !esu && !ers && !blk_any && !busy && !done));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && !swe && !esu && !ers));

endmodule

bind flash_erase_seq fe_seq_chk #(
  .ERASE_MAX_CYC(ERASE_MAX_CYC),
  .ADDR_W       (ADDR_W),
  .TOP_LIMIT    (TOP_LIMIT),
  .LO_BLKS      (LO_BLKS),
  .HI_BLKS      (HI_BLKS)
) u_fe_seq_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .addr    (addr),
  .swe     (swe),
  .esu     (esu),
  .ers     (ers),
  .blk_lo  (blk_lo),
  .blk_hi  (blk_hi),
  .busy    (busy),
  .done    (done),
  .timeout (timeout),
  .addr_err(addr_err)
);

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;

  localparam int P_SWE   = 3;
  localparam int P_ESU   = 6;
  localparam int P_ERASE = 10;
  localparam int P_MAX   = 16;
  localparam int P_HOLD  = 2;
  localparam int P_POST  = 5;
  localparam int P_WD    = 40;
  localparam int P_WD_SH = 12;

  localparam int E_BLK  = 1 + P_SWE;
  localparam int E_ESU  = E_BLK + 1;
  localparam int E_ERS  = E_ESU + P_ESU;
  localparam int E_ERSF = E_ERS + P_ERASE;
  localparam int E_ESUF = E_ERSF + P_HOLD;
  localparam int E_BLKF = E_ESUF + 1;
  localparam int E_SWEF = E_BLKF + 1;
  localparam int E_DONE = E_SWEF + P_POST;
  localparam int E_ABRT = E_BLK + P_WD_SH;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        start_a, start_b;
  logic [19:0] addr_a, addr_b;
  logic        swe_a, esu_a, ers_a, busy_a, done_a, to_a, err_a;
  logic        swe_b, esu_b, ers_b, busy_b, done_b, to_b, err_b;
  logic [7:0]  lo_a, lo_b;
  logic [6:0]  hi_a, hi_b;

  int n_chk  = 0;
  int n_fail = 0;

  flash_erase_seq #(
    .SWE_CYC(P_SWE), .ESU_CYC(P_ESU), .ERASE_CYC(P_ERASE), .ERASE_MAX_CYC(P_MAX),
    .HOLD_CYC(P_HOLD), .POST_CYC(P_POST), .WDOG_CYC(P_WD)
  ) u_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start_a), .addr(addr_a),
    .swe(swe_a), .esu(esu_a), .ers(ers_a), .blk_lo(lo_a), .blk_hi(hi_a),
    .busy(busy_a), .done(done_a), .timeout(to_a), .addr_err(err_a)
  );

  flash_erase_seq #(
    .SWE_CYC(P_SWE), .ESU_CYC(P_ESU), .ERASE_CYC(P_ERASE), .ERASE_MAX_CYC(P_MAX),
    .HOLD_CYC(P_HOLD), .POST_CYC(P_POST), .WDOG_CYC(P_WD_SH)
  ) u_flash_erase_seq_wd (
    .clk(clk), .rst_n(rst_n), .start(start_b), .addr(addr_b),
    .swe(swe_b), .esu(esu_b), .ers(ers_b), .blk_lo(lo_b), .blk_hi(hi_b),
    .busy(busy_b), .done(done_b), .timeout(to_b), .addr_err(err_b)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_sel(input logic [19:0] a);
    logic [7:0] lo;
    logic [6:0] hi;
    lo = '0;
    hi = '0;
    if (a < 20'h08000) lo[a[14:12]] = 1'b1;
    else               hi[int'(a >> 15) - 1] = 1'b1;
    return {hi, lo};
  endfunction

  // full sequence on the normal instance; optional mid-sequence request
  task automatic run_a(input logic [19:0] a, input int poke_at, input logic [19:0] poke_addr);
    int i_blk = -1, i_esu = -1, i_ers = -1, i_ersf = -1;
    int i_esuf = -1, i_blkf = -1, i_swef = -1, i_done = -1, i_busyf = -1;
    logic [14:0] cap = '0;
    logic p_blk = 1'b0, p_esu = 1'b0, p_ers = 1'b0, p_swe = 1'b0, p_done = 1'b0, p_busy = 1'b0;
    logic b_any;
    @(negedge clk);
    start_a = 1'b1;
    addr_a  = a;
    @(negedge clk);
    start_a = 1'b0;
    for (int idx = 1; idx <= E_DONE + 2; idx++) begin
      b_any = (|lo_a) || (|hi_a);
      if (idx == 1) begin
        check_eq("R2 swe raised first", int'(swe_a), 1);
        check_eq("R2 quiet strobes", int'({esu_a, ers_a, b_any}), 0);
        check_eq("R7 done cleared by start", int'(done_a), 0);
        check_eq("R9 addr_err cleared by start", int'(err_a), 0);
      end
      if (b_any && !p_blk && i_blk < 0) i_blk = idx;
      if (esu_a && !p_esu && i_esu < 0) i_esu = idx;
      if (ers_a && !p_ers && i_ers < 0) begin i_ers = idx; cap = {hi_a, lo_a}; end
      if (!ers_a && p_ers && i_ersf < 0) i_ersf = idx;
      if (!esu_a && p_esu && i_esuf < 0) i_esuf = idx;
      if (!b_any && p_blk && i_blkf < 0) i_blkf = idx;
      if (!swe_a && p_swe && i_swef < 0) i_swef = idx;
      if (done_a && !p_done && i_done < 0) i_done = idx;
      if (!busy_a && p_busy && i_busyf < 0) i_busyf = idx;
      p_blk = b_any; p_esu = esu_a; p_ers = ers_a; p_swe = swe_a;
      p_done = done_a; p_busy = busy_a;
      if (idx == poke_at) begin
        start_a = 1'b1;
        addr_a  = poke_addr;
      end else begin
        start_a = 1'b0;
      end
      @(negedge clk);
    end
    start_a = 1'b0;
    check_eq("R2 block load time", i_blk, E_BLK);
    check_eq("R4 esu rise time", i_esu, E_ESU);
    check_eq("R4 ers rise time", i_ers, E_ERS);
    check_eq("R5 erase pulse length", i_ersf - i_ers, P_ERASE);
    check_eq("R6 esu fall time", i_esuf, E_ESUF);
    check_eq("R6 block clear time", i_blkf, E_BLKF);
    check_eq("R6 swe fall time", i_swef, E_SWEF);
    check_eq("R7 done rise time", i_done, E_DONE);
    check_eq("R7 busy fall time", i_busyf, E_DONE);
    check_eq("R3 block decode", int'(cap), int'(exp_sel(a)));
    check_eq("R10 no abort on normal run", int'(to_a), 0);
    if (poke_at > 0) begin
      check_eq("R8 request while busy left no error", int'(err_a), 0);
      check_eq("R8 done held after ignored request", int'(done_a), 1);
    end
  endtask

  task automatic run_bad_a(input logic [19:0] a);
    logic prev_done;
    @(negedge clk);
    prev_done = done_a;
    start_a = 1'b1;
    addr_a  = a;
    @(negedge clk);
    start_a = 1'b0;
    check_eq("R9 addr_err set", int'(err_a), 1);
    check_eq("R9 strobes untouched", int'({swe_a, esu_a, ers_a, (|lo_a) || (|hi_a)}), 0);
    check_eq("R9 busy stays low", int'(busy_a), 0);
    check_eq("R9 done unchanged", int'(done_a), int'(prev_done));
    @(negedge clk);
    check_eq("R9 still no sequence", int'(swe_a), 0);
  endtask

  task automatic run_b(input logic [19:0] a);
    @(negedge clk);
    start_b = 1'b1;
    addr_b  = a;
    @(negedge clk);
    start_b = 1'b0;
    for (int idx = 1; idx <= E_ABRT + 4; idx++) begin
      if (idx == 1) check_eq("R10 timeout cleared by start", int'(to_b), 0);
      if (idx == E_BLK) check_eq("R10 block loaded", int'({hi_b, lo_b}), int'(exp_sel(a)));
      if (idx == E_ABRT - 1) begin
        check_eq("R10 erase running before abort", int'(ers_b), 1);
        check_eq("R10 timeout not yet", int'(to_b), 0);
      end
      if (idx == E_ABRT) begin
        check_eq("R10 all strobes low at abort",
                 int'({swe_b, esu_b, ers_b, (|lo_b) || (|hi_b)}), 0);
        check_eq("R10 timeout raised", int'(to_b), 1);
        check_eq("R10 busy low after abort", int'(busy_b), 0);
        check_eq("R10 done stays low", int'(done_b), 0);
      end
      @(negedge clk);
    end
    check_eq("R10 timeout sticky", int'(to_b), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [19:0] ra;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start_a = 1'b0; start_b = 1'b0;
    addr_a = '0;    addr_b = '0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset outputs a",
             int'({swe_a, esu_a, ers_a, lo_a, hi_a, busy_a, done_a, to_a, err_a}), 0);
    check_eq("R1 reset outputs b",
             int'({swe_b, esu_b, ers_b, lo_b, hi_b, busy_b, done_b, to_b, err_b}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 idle after reset", int'({busy_a, done_a, to_a, err_a}), 0);

    run_a(20'h00000, 0, '0);
    run_a(20'h07FFF, 0, '0);
    run_a(20'h08000, 0, '0);
    run_a(20'h3FFFF, 0, '0);
    run_bad_a(20'h40000);
    run_a(20'h12345, 0, '0);
    run_bad_a(20'hFFFFF);
    run_a(20'h04321, 8, 20'h7FFFF);
    run_a(20'h20000, 15, 20'h01000);

    for (int k = 0; k < 30; k++) begin
      ra = 20'($urandom % 32'h48000);
      if (ra >= 20'h40000) run_bad_a(ra);
      else if (($urandom % 4) == 0) run_a(ra, 2 + int'($urandom % 25), 20'($urandom % 32'h48000));
      else run_a(ra, 0, '0);
    end

    run_b(20'h09000);
    run_b(20'h00800);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule